// File: doc/BRIEF.md
# Eight-Bit ALU with Nibble Flags

This block is the combinational arithmetic and logic unit of a small eight-bit processor core. In one pass it takes an accumulator operand, a second operand, the current flag byte and a four-bit operation code. It returns a result, a write-back enable that tells the register file whether to store that result, and the next flag byte. The flag byte carries zero, subtract, half-carry and carry in its upper nibble.

Each operation has its own flag rules. Some flags are computed, some are forced to a fixed value, and some are copied from the incoming byte. This is what lets the core's decimal-adjust step work: it reads the subtract and half-carry flags left by the previous addition or subtraction and corrects the accumulator to packed BCD. A sixteen-bit mode adds two register pairs. In that mode the half-carry is taken from bit 11 and the carry from bit 15.

The unit holds no state. The core registers the outputs in its own pipeline.

Top module: `nibble_flag_alu`

## Requirements
- R1: The operation codes are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 compare, 5 AND, 6 OR, 7 XOR, 8 increment, 9 decrement, 10 complement, 11 set carry, 12 complement carry, 13 decimal adjust and 14 wide add. Write-back is high for every code except 4, 11, 12 and 15. For every 8-bit operation, bits 15..8 of the result are zero.
- R2: The flag byte holds zero in bit 7, subtract in bit 6, half-carry in bit 5 and carry in bit 4. Bits 3..0 of the output flag byte are always zero, whatever the input flag byte holds.
- R3: Add and add-with-carry return the 8-bit sum and clear subtract. Zero is set when the sum is zero. Half-carry is the carry out of bit 3, counting the carry-in. Carry is the carry out of bit 7. Add-with-carry uses the incoming carry flag as carry-in; plain add ignores it.
- R4: Subtract and subtract-with-borrow return the 8-bit difference and set subtract. Half-carry is the borrow out of bit 3, counting the borrow-in. Carry is set when the full difference is negative. Subtract-with-borrow takes the incoming carry flag as borrow-in.
- R5: Compare produces the same flags and the same result value as subtract, with write-back low.
- R6: AND sets half-carry and clears subtract and carry. OR and XOR clear subtract, half-carry and carry. For all three, zero is set when the result is zero.
- R7: Increment and decrement act on the accumulator and keep the incoming carry. Increment clears subtract and sets half-carry when the low nibble was 0xF. Decrement sets subtract and sets half-carry when the low nibble was 0x0.
- R8: Complement inverts the accumulator, sets subtract and half-carry, and keeps zero and carry. Set carry and complement carry keep zero, clear subtract and half-carry, and set or invert carry with write-back low.
- R9: When the incoming subtract flag is clear, decimal adjust first adds 0x60 and sets carry if carry was set or the accumulator was above 0x99. It then adds 0x06 if half-carry was set or the low nibble is above 9. Otherwise carry is kept.
- R10: When the incoming subtract flag is set, decimal adjust subtracts 0x60 if carry was set and 0x06 if half-carry was set, and keeps carry. In both directions of decimal adjust, half-carry is cleared, subtract is kept and zero reflects the adjusted value.
- R11: Wide add returns the 16-bit sum of both full operands and clears subtract. Half-carry is the carry out of bit 11, carry is the carry out of bit 15, and zero is kept.
- R12: Code 15 is idle: the result is zero, write-back is low, and the flags pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 4 | Operation code (see R1) |
| opA | input | 16 | Accumulator in bits 7..0; first register pair in wide add |
| opB | input | 16 | Second operand in bits 7..0; second register pair in wide add |
| flagsIn | input | 8 | Current flag byte |
| result | output | 16 | Operation result |
| wbEn | output | 1 | Result should be written back |
| flagsOut | output | 8 | Next flag byte |

## Verification
The riskiest coincidence is a nibble-level carry and a full-width carry arising from the same operation, when the incoming carry flag feeds both as a carry-in or borrow-in. Examples are 0xFF plus 0x01, borrow through zero with borrow-in set, and decimal adjust where both the 0x60 and the 0x06 corrections apply. Directed vectors target each of these cases. A random sweep compares every operation code against an integer model written from the requirements.

A second collision is an operation that writes the result while leaving some flags untouched, such as complement, increment or decrement. These are judged by driving flag bytes whose preserved bits differ from what a recomputation would produce.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBC = 4'd3,
    OP_CMP = 4'd4, OP_AND = 4'd5, OP_OR = 4'd6, OP_XOR = 4'd7,
    OP_INC = 4'd8, OP_DEC = 4'd9, OP_CPL = 4'd10, OP_SCF = 4'd11,
    OP_CCF = 4'd12, OP_DAA = 4'd13, OP_ADD16 = 4'd14, OP_IDLE = 4'd15
  } aluOp_e;

  typedef enum logic [3:0] {
    U_ARITH, U_AND, U_OR, U_XOR, U_INC, U_DEC, U_CPL,
    U_SCF, U_CCF, U_DAA, U_WIDE, U_HOLD
  } unit_e;

  typedef struct packed {
    unit_e unit;
    logic  subMode;
    logic  carryIn;
    logic  writeBack;
  } aluStrobe_t;

  localparam int FLAG_Z = 7;
  localparam int FLAG_N = 6;
  localparam int FLAG_H = 5;
  localparam int FLAG_C = 4;
endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  aluOp_e     opCode,
  output aluStrobe_t strb
);
  always_comb begin
    strb = '{unit: U_HOLD, subMode: 1'b0, carryIn: 1'b0, writeBack: 1'b1};
    unique case (opCode)
      OP_ADD:   strb.unit = U_ARITH;
      OP_ADC:   begin strb.unit = U_ARITH; strb.carryIn = 1'b1; end
      OP_SUB:   begin strb.unit = U_ARITH; strb.subMode = 1'b1; end
      OP_SBC:   begin strb.unit = U_ARITH; strb.subMode = 1'b1; strb.carryIn = 1'b1; end
      OP_CMP:   begin strb.unit = U_ARITH; strb.subMode = 1'b1; strb.writeBack = 1'b0; end
      OP_AND:   strb.unit = U_AND;
      OP_OR:    strb.unit = U_OR;
      OP_XOR:   strb.unit = U_XOR;
      OP_INC:   strb.unit = U_INC;
      OP_DEC:   strb.unit = U_DEC;
      OP_CPL:   strb.unit = U_CPL;
      OP_SCF:   begin strb.unit = U_SCF; strb.writeBack = 1'b0; end
      OP_CCF:   begin strb.unit = U_CCF; strb.writeBack = 1'b0; end
      OP_DAA:   strb.unit = U_DAA;
      OP_ADD16: strb.unit = U_WIDE;
      OP_IDLE:  begin strb.unit = U_HOLD; strb.writeBack = 1'b0; end
      default:  begin strb.unit = U_HOLD; strb.writeBack = 1'b0; end
    endcase
  end
endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  aluStrobe_t          strb,
  input  logic [2*DATA_W-1:0] opA,
  input  logic [2*DATA_W-1:0] opB,
  input  logic [7:0]          flagsIn,
  output logic [2*DATA_W-1:0] result,
  output logic [7:0]          flagsOut
);
  localparam int WIDE_W = 2 * DATA_W;
  localparam int WIDE_H = WIDE_W - NIB_W;

  logic [DATA_W-1:0] accV, srcV, res8, daaHi, daaOut;
  logic zIn, nIn, hIn, cIn, cinBit, daaC;
  logic zOut, nOut, hOut, cOut;
  logic [DATA_W:0] addFull, subFull;
  logic [NIB_W:0]  addNib, subNib;
  logic [WIDE_W:0] wideFull;
  logic [WIDE_H:0] wideLow;
  logic [3:0]      unusedLowFlags;

  assign accV   = opA[DATA_W-1:0];
  assign srcV   = opB[DATA_W-1:0];
  assign zIn    = flagsIn[FLAG_Z];
  assign nIn    = flagsIn[FLAG_N];
  assign hIn    = flagsIn[FLAG_H];
  assign cIn    = flagsIn[FLAG_C];
  assign unusedLowFlags = flagsIn[3:0];
  assign cinBit = strb.carryIn & cIn;

  assign addFull  = {1'b0, accV} + {1'b0, srcV} + {{DATA_W{1'b0}}, cinBit};
  assign subFull  = {1'b0, accV} - {1'b0, srcV} - {{DATA_W{1'b0}}, cinBit};
  assign addNib   = {1'b0, accV[NIB_W-1:0]} + {1'b0, srcV[NIB_W-1:0]} + {{NIB_W{1'b0}}, cinBit};
  assign subNib   = {1'b0, accV[NIB_W-1:0]} - {1'b0, srcV[NIB_W-1:0]} - {{NIB_W{1'b0}}, cinBit};
  assign wideFull = {1'b0, opA} + {1'b0, opB};
  assign wideLow  = {1'b0, opA[WIDE_H-1:0]} + {1'b0, opB[WIDE_H-1:0]};

  // decimal correction, direction chosen by the incoming subtract flag
  always_comb begin
    if (!nIn) begin
      daaC   = cIn | (accV > DATA_W'(8'h99));
      daaHi  = daaC ? accV + DATA_W'(8'h60) : accV;
      daaOut = (hIn | (daaHi[NIB_W-1:0] > NIB_W'(9))) ? daaHi + DATA_W'(8'h06) : daaHi;
    end else begin
      daaC   = cIn;
      daaHi  = cIn ? accV - DATA_W'(8'h60) : accV;
      daaOut = hIn ? daaHi - DATA_W'(8'h06) : daaHi;
    end
  end

  always_comb begin
    res8 = '0;
    zOut = zIn; nOut = nIn; hOut = hIn; cOut = cIn;
    unique case (strb.unit)
      U_ARITH: begin
        res8 = strb.subMode ? subFull[DATA_W-1:0] : addFull[DATA_W-1:0];
        nOut = strb.subMode;
        hOut = strb.subMode ? subNib[NIB_W] : addNib[NIB_W];
        cOut = strb.subMode ? subFull[DATA_W] : addFull[DATA_W];
        zOut = (res8 == '0);
      end
      U_AND: begin res8 = accV & srcV; zOut = (res8 == '0); nOut = 1'b0; hOut = 1'b1; cOut = 1'b0; end
      U_OR:  begin res8 = accV | srcV; zOut = (res8 == '0); nOut = 1'b0; hOut = 1'b0; cOut = 1'b0; end
      U_XOR: begin res8 = accV ^ srcV; zOut = (res8 == '0); nOut = 1'b0; hOut = 1'b0; cOut = 1'b0; end
      U_INC: begin
        res8 = accV + DATA_W'(1);
        zOut = (res8 == '0); nOut = 1'b0; hOut = (accV[NIB_W-1:0] == {NIB_W{1'b1}});
      end
      U_DEC: begin
        res8 = accV - DATA_W'(1);
        zOut = (res8 == '0); nOut = 1'b1; hOut = (accV[NIB_W-1:0] == '0);
      end
      U_CPL: begin res8 = ~accV; nOut = 1'b1; hOut = 1'b1; end
      U_SCF: begin nOut = 1'b0; hOut = 1'b0; cOut = 1'b1; end
      U_CCF: begin nOut = 1'b0; hOut = 1'b0; cOut = ~cIn; end
      U_DAA: begin res8 = daaOut; zOut = (daaOut == '0); hOut = 1'b0; cOut = daaC; end
      U_WIDE: begin nOut = 1'b0; hOut = wideLow[WIDE_H]; cOut = wideFull[WIDE_W]; end
      default: ;
    endcase
  end

  assign result   = (strb.unit == U_WIDE) ? wideFull[WIDE_W-1:0] : {{DATA_W{1'b0}}, res8};
  assign flagsOut = {zOut, nOut, hOut, cOut, 4'b0000};

  always_comb begin
    if (strb.unit == U_INC || strb.unit == U_DEC)
      a_r7_carry_kept: assert (flagsOut[FLAG_C] == flagsIn[FLAG_C]) else $error("R7 carry changed");
    if (strb.unit == U_AND || strb.unit == U_OR || strb.unit == U_XOR)
      a_r6_logic_carry_clear: assert (!flagsOut[FLAG_C]) else $error("R6 carry set");
    if (strb.unit == U_WIDE)
      a_r11_wide_zero_kept: assert (flagsOut[FLAG_Z] == flagsIn[FLAG_Z]) else $error("R11 zero changed");
    if (strb.unit == U_ARITH && strb.subMode)
      a_r4_sub_sets_n: assert (flagsOut[FLAG_N]) else $error("R4 subtract flag clear");
  end
endmodule

// File: rtl/nibble_flag_alu.sv
module nibble_flag_alu
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [3:0]          opSel,
  input  logic [2*DATA_W-1:0] opA,
  input  logic [2*DATA_W-1:0] opB,
  input  logic [7:0]          flagsIn,
  output logic [2*DATA_W-1:0] result,
  output logic                wbEn,
  output logic [7:0]          flagsOut
);
  aluOp_e     opCode;
  aluStrobe_t strb;

  assign opCode = aluOp_e'(opSel);

  alu8_ctrl u_ctrl (.opCode(opCode), .strb(strb));

  alu8_datapath #(.DATA_W(DATA_W)) u_dp (
    .strb(strb), .opA(opA), .opB(opB), .flagsIn(flagsIn),
    .result(result), .flagsOut(flagsOut)
  );

  assign wbEn = strb.writeBack;

  always_comb begin
    if (opSel == 4'd4)
      a_r5_cmp_no_wb: assert (!wbEn) else $error("R5 compare wrote back");
    if (opSel == 4'd15)
      a_r12_idle_flags: assert (flagsOut[7:4] == flagsIn[7:4] && !wbEn) else $error("R12 idle altered state");
  end
endmodule

// File: tb/sim_nibble_flag_alu.sv
`timescale 1ns/1ps
module sim_nibble_flag_alu;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [3:0]  opSel = 4'd15;
  logic [15:0] opA = '0, opB = '0, result;
  logic [7:0]  flagsIn = '0, flagsOut;
  logic        wbEn;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [15:0] res;
    logic        wb;
    logic [7:0]  fl;
    string       tag;
  } exp_t;
  exp_t sb[$];

  nibble_flag_alu u0 (.opSel(opSel), .opA(opA), .opB(opB), .flagsIn(flagsIn),
                      .result(result), .wbEn(wbEn), .flagsOut(flagsOut));

  task automatic expectOp(input int op, input int a, input int b, input int f,
                          input int res, input int wb, input int fl, input string tag);
    exp_t e;
    @(posedge clk);
    opSel = 4'(op); opA = 16'(a); opB = 16'(b); flagsIn = 8'(f);
    e.res = 16'(res); e.wb = wb[0]; e.fl = 8'(fl); e.tag = tag;
    sb.push_back(e);
  endtask

  // integer reference written from the requirements
  task automatic model(input int op, input int a16, input int b16, input int f,
                       output int res, output int wb, output int fo);
    int a = a16 & 255, b = b16 & 255, r = 0, cin = 0;
    int z = (f >> 7) & 1, n = (f >> 6) & 1, h = (f >> 5) & 1, c = (f >> 4) & 1;
    wb = 1;
    case (op)
      0, 1: begin cin = (op == 1) ? c : 0; r = a + b + cin;
              h = ((a & 15) + (b & 15) + cin) > 15 ? 1 : 0; c = r > 255 ? 1 : 0;
              r &= 255; z = (r == 0); n = 0; end
      2, 3, 4: begin cin = (op == 3) ? c : 0; r = a - b - cin;
              h = ((a & 15) - (b & 15) - cin) < 0 ? 1 : 0; c = r < 0 ? 1 : 0;
              r &= 255; z = (r == 0); n = 1; wb = (op != 4); end
      5: begin r = a & b; z = (r == 0); n = 0; h = 1; c = 0; end
      6: begin r = a | b; z = (r == 0); n = 0; h = 0; c = 0; end
      7: begin r = a ^ b; z = (r == 0); n = 0; h = 0; c = 0; end
      8: begin h = ((a & 15) == 15); r = (a + 1) & 255; z = (r == 0); n = 0; end
      9: begin h = ((a & 15) == 0); r = (a - 1) & 255; z = (r == 0); n = 1; end
      10: begin r = (~a) & 255; n = 1; h = 1; end
      11: begin n = 0; h = 0; c = 1; wb = 0; end
      12: begin n = 0; h = 0; c = 1 - c; wb = 0; end
      13: begin
        if (n == 0) begin
          if (c == 1 || a > 'h99) begin a += 'h60; c = 1; end
          if (h == 1 || (a & 15) > 9) a += 6;
        end else begin
          if (c == 1) a -= 'h60;
          if (h == 1) a -= 6;
        end
        r = a & 255; z = (r == 0); h = 0;
      end
      14: begin r = a16 + b16; h = ((a16 & 'hfff) + (b16 & 'hfff)) > 'hfff ? 1 : 0;
            c = r > 'hffff ? 1 : 0; r &= 'hffff; n = 0; end
      default: begin r = 0; wb = 0; end
    endcase
    res = r;
    fo = (z << 7) | (n << 6) | (h << 5) | (c << 4);
  endtask

  // monitor: compares design outputs mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (result !== e.res || wbEn !== e.wb || flagsOut !== e.fl) begin
          errors++;
          $display("FAIL %s: got res=%h wb=%b fl=%h expected res=%h wb=%b fl=%h",
                   e.tag, result, wbEn, flagsOut, e.res, e.wb, e.fl);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // R12 idle / out-of-reset state
    expectOp(15, 'h0000, 'h0000, 'h00, 'h0000, 0, 'h00, "R12 idle zero");
    expectOp(15, 'h1234, 'h5678, 'hFF, 'h0000, 0, 'hF0, "R12 R2 idle pass");
    // R3 add
    expectOp(0, 'h3A, 'hC6, 'h00, 'h00, 1, 'hB0, "R3 add wrap");
    expectOp(0, 'h08, 'h08, 'h00, 'h10, 1, 'h20, "R3 add half");
    expectOp(0, 'h0F, 'h00, 'h10, 'h0F, 1, 'h00, "R3 add ignores carry");
    expectOp(1, 'h0F, 'h00, 'h1F, 'h10, 1, 'h20, "R3 R2 adc carry-in");
    expectOp(0, 'hFF01, 'h0001, 'h00, 'h0002, 1, 'h00, "R1 upper byte zero");
    // R4 subtract
    expectOp(2, 'h3E, 'h3E, 'h00, 'h00, 1, 'hC0, "R4 sub zero");
    expectOp(2, 'h10, 'h01, 'h00, 'h0F, 1, 'h60, "R4 sub half borrow");
    expectOp(3, 'h00, 'h00, 'h10, 'hFF, 1, 'h70, "R4 sbc borrow-in");
    // R5 compare
    expectOp(4, 'h20, 'h30, 'h00, 'hF0, 0, 'h50, "R5 compare");
    // R6 logic
    expectOp(5, 'hF0, 'h0F, 'h50, 'h00, 1, 'hA0, "R6 and");
    expectOp(6, 'h00, 'h00, 'h70, 'h00, 1, 'h80, "R6 or");
    expectOp(7, 'h5A, 'hFF, 'hF0, 'hA5, 1, 'h00, "R6 xor");
    // R7 inc/dec
    expectOp(8, 'hFF, 'h00, 'h10, 'h00, 1, 'hB0, "R7 inc wrap");
    expectOp(8, 'h0F, 'h00, 'h40, 'h10, 1, 'h20, "R7 inc half");
    expectOp(9, 'h10, 'h00, 'h10, 'h0F, 1, 'h70, "R7 dec half");
    expectOp(9, 'h01, 'h00, 'h00, 'h00, 1, 'hC0, "R7 dec zero");
    // R8 complement and carry ops
    expectOp(10, 'h35, 'h00, 'h90, 'hCA, 1, 'hF0, "R8 cpl");
    expectOp(11, 'h00, 'h00, 'hE0, 'h00, 0, 'h90, "R8 scf");
    expectOp(12, 'h00, 'h00, 'h10, 'h00, 0, 'h00, "R8 ccf clear");
    expectOp(12, 'h00, 'h00, 'h8F, 'h00, 0, 'h90, "R8 R2 ccf set");
    // R9 / R10 decimal adjust
    expectOp(13, 'h3C, 'h00, 'h00, 'h42, 1, 'h00, "R9 daa low");
    expectOp(13, 'h9A, 'h00, 'h00, 'h00, 1, 'h90, "R9 daa both");
    expectOp(13, 'h1F, 'h00, 'h60, 'h19, 1, 'h40, "R10 daa sub half");
    expectOp(13, 'hF0, 'h00, 'h50, 'h90, 1, 'h50, "R10 daa sub carry");
    // R11 wide add
    expectOp(14, 'h0FFF, 'h0001, 'h80, 'h1000, 1, 'hA0, "R11 wide half");
    expectOp(14, 'hFFFF, 'h0001, 'h00, 'h0000, 1, 'h30, "R11 wide wrap");
    expectOp(14, 'h8000, 'h8000, 'h40, 'h0000, 1, 'h10, "R11 wide carry");
    // random sweep of every code against the model
    for (int i = 0; i < 600; i++) begin
      int op, a, b, f, r, w, fo;
      op = int'($urandom_range(0, 15));
      a = int'($urandom_range(0, 65535));
      b = int'($urandom_range(0, 65535));
      f = int'($urandom_range(0, 255));
      model(op, a, b, f, r, w, fo);
      expectOp(op, a, b, f, r, w, fo, "R1 random sweep");
    end
    repeat (3) @(posedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule